// File: doc/BRIEF.md
# Clock-Style Interrupt Scheduler

This block produces the three classic real-time-clock interrupt kinds (once-per-second update, time-of-day alarm and periodic) from a free-running tick counter and a single one-shot comparator channel. It keeps its own comparator value. Whenever the external counter reaches that value, the block runs one wake-up. It moves the comparator forward by one wake-up interval, works out which interrupt kinds are due, and emits a status word together with a one-cycle interrupt pulse. The current hours, minutes and seconds come from an external time source.

The wake-up rate is a base poll rate of 64 Hz. When the periodic source is enabled with a faster rate, the block polls at that faster rate instead. Slower periodic rates are derived from the wake-ups by a sub-count. The number of counter ticks per wake-up is computed with a sequential divider whenever the wake-up rate changes. If a wake-up is serviced so late that the counter has already passed the next scheduled value, the block finds out how many wake-ups were missed. It then moves the comparator past all of them plus one spare interval, and credits the missed wake-ups to the periodic sub-count.

Top module: `rtc_wake_sched`

## Requirements
- R1: After reset, `cmp_active_o`, `irq_o` and `status_o` are all 0. When a wake-up finds all three sources disabled, the comparator channel goes inactive and no interrupt is raised.
- R2: Enabling any source while all three were off arms the comparator at the counter value plus one interval. Arming happens only once the divider result is ready.
- R3: Ticks per wake-up is `floor(TICKS_PER_SEC / 2^w)`. Here `w` is the programmed rate code if periodic is enabled and that code exceeds 6; otherwise `w` is 6 (64 Hz).
- R4: The periodic rate is written as a log2 code, where code k means 2^k Hz. Codes below 1 are stored as 1 (2 Hz) and codes above 13 are stored as 13 (8192 Hz). After reset the code is 6.
- R5: On a wake-up that is on time, the next comparator value is the previous comparator value plus the ticks per wake-up.
- R6: If the counter already lies past the advanced comparator value (signed difference greater than zero), then missed = difference / ticks + 2. The comparator moves forward by missed intervals beyond the advanced value, and missed is added to the periodic sub-count.
- R7: With update enabled, a wake-up raises the update flag when the seconds input differs from the last recorded seconds (0 after reset). The recorded value is then replaced.
- R8: With periodic enabled, each wake-up increments the sub-count. When the sub-count reaches wake-up rate / periodic rate, the periodic flag is raised and the sub-count returns to 0.
- R9: With alarm enabled, a wake-up raises the alarm flag when hours, minutes and seconds all equal the programmed alarm time.
- R10: Setting the periodic enable, or writing a rate, clears the sub-count.
- R11: When any flag is raised, `irq_o` pulses for one cycle and `status_o` is loaded at the same time. The status word has bit 4 for update, bit 5 for alarm, bit 6 for periodic, bit 7 as the pending bit, bits 15:8 equal to 1, and bits 3:0 equal to 0. `status_o` holds its value until the next interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | CNT_W | Free-running tick counter |
| time_sec_i | input | 6 | Current seconds |
| time_min_i | input | 6 | Current minutes |
| time_hr_i | input | 5 | Current hours |
| src_set_i | input | 3 | Enable-set mask: bit0 update, bit1 alarm, bit2 periodic |
| src_clr_i | input | 3 | Enable-clear mask, same bits; the set mask wins on overlap |
| alarm_wr_i | input | 1 | Alarm time write strobe |
| alarm_sec_i | input | 6 | Alarm seconds |
| alarm_min_i | input | 6 | Alarm minutes |
| alarm_hr_i | input | 5 | Alarm hours |
| rate_wr_i | input | 1 | Periodic rate write strobe |
| rate_log_i | input | 4 | Periodic rate as a log2 code |
| irq_o | output | 1 | One-cycle interrupt pulse |
| status_o | output | 16 | Interrupt status word |
| cmp_active_o | output | 1 | Comparator channel enabled |
| cmp_value_o | output | CNT_W | Current comparator value |
| ticks_o | output | CNT_W | Ticks per wake-up in use |

## Verification
The bench sweeps rate codes, including out-of-range codes, and checks the tick interval, the arming value and the wake-up on which the periodic flag first appears. A design that clamped wrongly, or failed to raise the poll rate for fast periodic rates, would show a wrong interval or a mistimed flag. A late wake-up is forced, and the comparator is checked to land five intervals ahead. The following flag is checked to come three wake-ups later; a design that skipped no spare interval, or did not credit the sub-count, would miss both checks. Further checks cover:
- a repeated seconds value, which must raise no update;
- a one-field alarm mismatch, which must raise nothing;
- a rate rewrite in mid-count, which must restart the sub-count;
- a wake-up with every source cleared, which must drop the channel silently.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;

  localparam int N_SRC    = 3;
  localparam int SRC_UPD  = 0;
  localparam int SRC_ALM  = 1;
  localparam int SRC_PER  = 2;
  localparam int LOG_W    = 4;
  localparam logic [LOG_W-1:0] LOG_BASE = 4'd6;
  localparam logic [LOG_W-1:0] LOG_MIN  = 4'd1;
  localparam logic [LOG_W-1:0] LOG_MAX  = 4'd13;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_RUN,
    ST_LATE,
    ST_EVAL
  } sched_st_t;

  // keep a programmed rate code inside the legal range
  function automatic logic [LOG_W-1:0] clamp_log(input logic [LOG_W-1:0] v);
    if (v < LOG_MIN) return LOG_MIN;
    if (v > LOG_MAX) return LOG_MAX;
    return v;
  endfunction

  // poll rate code: base rate unless a faster periodic rate is active
  function automatic logic [LOG_W-1:0] wake_log(input logic per_on,
                                                input logic [LOG_W-1:0] rl);
    return (per_on && (rl > LOG_BASE)) ? rl : LOG_BASE;
  endfunction

  // wake-ups per periodic flag = 2^(wake code - rate code)
  function automatic logic [31:0] per_threshold(input logic [LOG_W-1:0] wl,
                                                input logic [LOG_W-1:0] rl);
    if (rl > wl) return 32'd1;
    return 32'd1 << (wl - rl);
  endfunction

  // comparator after a skip: cnt - rem + 2*ticks
  function automatic logic [63:0] skip_target(input logic [63:0] cnt,
                                              input logic [63:0] rem,
                                              input logic [63:0] ticks);
    return cnt - rem + (ticks << 1);
  endfunction

  function automatic logic [63:0] sat_add(input logic [63:0] a,
                                          input logic [63:0] b,
                                          input int unsigned w);
    logic [64:0] s;
    logic [64:0] lim;
    s   = {1'b0, a} + {1'b0, b};
    lim = (65'd1 << w) - 65'd1;
    return (s > lim) ? lim[63:0] : s[63:0];
  endfunction

  function automatic logic [15:0] make_status(input logic upd,
                                              input logic alm,
                                              input logic per);
    if (!(upd || alm || per)) return 16'h0000;
    return {8'd1, 1'b1, per, alm, upd, 4'b0000};
  endfunction

endpackage

// File: rtl/rtc_seq_div.sv
module rtc_seq_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  dsr_q;
  logic [CW-1:0] left_q;
  logic          busy_q;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  always_comb begin
    shifted = {rem_o, quot_o[W-1]};
    trial   = shifted - {1'b0, dsr_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsr_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
      quot_o <= '0;
      rem_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        dsr_q  <= divisor_i;
        quot_o <= dividend_i;
        rem_o  <= '0;
        left_q <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (!trial[W]) begin
          rem_o  <= trial[W-1:0];
          quot_o <= {quot_o[W-2:0], 1'b1};
        end else begin
          rem_o  <= shifted[W-1:0];
          quot_o <= {quot_o[W-2:0], 1'b0};
        end
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_src_regs.sv
module rtc_src_regs
  import rtc_wake_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic             alarm_wr_i,
  input  logic [5:0]       alarm_sec_i,
  input  logic [5:0]       alarm_min_i,
  input  logic [4:0]       alarm_hr_i,
  input  logic             rate_wr_i,
  input  logic [LOG_W-1:0] rate_log_i,
  output logic [N_SRC-1:0] en_o,
  output logic [5:0]       al_sec_o,
  output logic [5:0]       al_min_o,
  output logic [4:0]       al_hr_o,
  output logic [LOG_W-1:0] rate_log_o,
  output logic             arm_evt_o,
  output logic             sub_clr_o
);
  logic [N_SRC-1:0] en_next;

  always_comb begin
    en_next   = (en_o & ~clr_i) | set_i;
    arm_evt_o = (en_o == '0) && (en_next != '0);
    sub_clr_o = rate_wr_i | set_i[SRC_PER];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o       <= '0;
      al_sec_o   <= '0;
      al_min_o   <= '0;
      al_hr_o    <= '0;
      rate_log_o <= LOG_BASE;
    end else begin
      en_o <= en_next;
      if (alarm_wr_i) begin
        al_sec_o <= alarm_sec_i;
        al_min_o <= alarm_min_i;
        al_hr_o  <= alarm_hr_i;
      end
      if (rate_wr_i) rate_log_o <= clamp_log(rate_log_i);
    end
  end
endmodule

// File: rtl/rtc_flag_eval.sv
module rtc_flag_eval
  import rtc_wake_pkg::*;
#(
  parameter int SUB_W = 32
) (
  input  logic [N_SRC-1:0] en_i,
  input  logic [5:0]       sec_i,
  input  logic [5:0]       min_i,
  input  logic [4:0]       hr_i,
  input  logic [5:0]       al_sec_i,
  input  logic [5:0]       al_min_i,
  input  logic [4:0]       al_hr_i,
  input  logic [5:0]       last_sec_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [SUB_W-1:0] thr_i,
  output logic             upd_hit_o,
  output logic             alm_hit_o,
  output logic             per_hit_o,
  output logic [SUB_W-1:0] sub_next_o,
  output logic [15:0]      status_next_o,
  output logic             any_o
);
  logic [SUB_W-1:0] sub_inc;

  always_comb begin
    sub_inc   = SUB_W'(sat_add(64'(sub_i), 64'd1, SUB_W));
    upd_hit_o = en_i[SRC_UPD] && (sec_i != last_sec_i);
    alm_hit_o = en_i[SRC_ALM] && (sec_i == al_sec_i) &&
                (min_i == al_min_i) && (hr_i == al_hr_i);
    per_hit_o = en_i[SRC_PER] && (sub_inc >= thr_i);
    if (!en_i[SRC_PER])  sub_next_o = sub_i;
    else if (per_hit_o)  sub_next_o = '0;
    else                 sub_next_o = sub_inc;
    status_next_o = make_status(upd_hit_o, alm_hit_o, per_hit_o);
    any_o         = upd_hit_o | alm_hit_o | per_hit_o;
  end
endmodule

// File: rtl/rtc_wake_sched.sv
module rtc_wake_sched
  import rtc_wake_pkg::*;
#(
  parameter int CNT_W         = 32,
  parameter int TICKS_PER_SEC = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [5:0]       time_sec_i,
  input  logic [5:0]       time_min_i,
  input  logic [4:0]       time_hr_i,
  input  logic [2:0]       src_set_i,
  input  logic [2:0]       src_clr_i,
  input  logic             alarm_wr_i,
  input  logic [5:0]       alarm_sec_i,
  input  logic [5:0]       alarm_min_i,
  input  logic [4:0]       alarm_hr_i,
  input  logic             rate_wr_i,
  input  logic [3:0]       rate_log_i,
  output logic             irq_o,
  output logic [15:0]      status_o,
  output logic             cmp_active_o,
  output logic [CNT_W-1:0] cmp_value_o,
  output logic [CNT_W-1:0] ticks_o
);
  localparam logic [CNT_W-1:0] TPS = CNT_W'(TICKS_PER_SEC);

  // configuration
  logic [N_SRC-1:0] en;
  logic [5:0]       al_sec, al_min;
  logic [4:0]       al_hr;
  logic [LOG_W-1:0] rate_log;
  logic             arm_evt, sub_clr;

  rtc_src_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (src_set_i),
    .clr_i      (src_clr_i),
    .alarm_wr_i (alarm_wr_i),
    .alarm_sec_i(alarm_sec_i),
    .alarm_min_i(alarm_min_i),
    .alarm_hr_i (alarm_hr_i),
    .rate_wr_i  (rate_wr_i),
    .rate_log_i (rate_log_i),
    .en_o       (en),
    .al_sec_o   (al_sec),
    .al_min_o   (al_min),
    .al_hr_o    (al_hr),
    .rate_log_o (rate_log),
    .arm_evt_o  (arm_evt),
    .sub_clr_o  (sub_clr)
  );

  // scheduler state
  sched_st_t        st_q;
  logic             arm_pend_q;
  logic [LOG_W-1:0] ticks_log_q;
  logic [CNT_W-1:0] skip_base;
  logic [CNT_W-1:0] sub_q;
  logic [5:0]       last_sec_q;
  logic             irq_q;
  logic [15:0]      status_q;

  // divider interface
  logic             div_start;
  logic [CNT_W-1:0] div_dvd, div_dsr;
  logic             div_done;
  logic [CNT_W-1:0] div_quot, div_rem;

  rtc_seq_div #(.W(CNT_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (div_start),
    .dividend_i(div_dvd),
    .divisor_i (div_dsr),
    .done_o    (div_done),
    .quot_o    (div_quot),
    .rem_o     (div_rem)
  );

  // named events and arithmetic
  logic [LOG_W-1:0] wl;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] next_cmp, late_d, reach_d;
  logic             reached, late, need_calc, any_en;
  logic             ev_ontime, ev_calc_done, ev_skip_done, ev_go_late, ev_retire;
  logic [CNT_W-1:0] calc_ticks, skip_cmp, missed;

  always_comb begin
    wl         = wake_log(en[SRC_PER], rate_log);
    thr        = CNT_W'(per_threshold(wl, rate_log));
    any_en     = (en != '0);
    next_cmp   = cmp_value_o + ticks_o;
    late_d     = count_i - next_cmp;
    late       = !late_d[CNT_W-1] && (late_d != '0);
    reach_d    = count_i - cmp_value_o;
    reached    = cmp_active_o && !reach_d[CNT_W-1];
    need_calc  = arm_pend_q || (cmp_active_o && (wl != ticks_log_q));
    calc_ticks = (div_quot == '0) ? CNT_W'(1) : div_quot;
    skip_cmp   = CNT_W'(skip_target(64'(skip_base), 64'(div_rem), 64'(ticks_o)));
    missed     = CNT_W'(sat_add(64'(div_quot), 64'd2, CNT_W));

    ev_calc_done = (st_q == ST_CALC) && div_done;
    ev_skip_done = (st_q == ST_LATE) && div_done;
    ev_retire    = (st_q == ST_RUN) && !need_calc && reached && !any_en;
    ev_go_late   = (st_q == ST_RUN) && !need_calc && reached && any_en && late;
    ev_ontime    = (st_q == ST_RUN) && !need_calc && reached && any_en && !late;

    div_start = 1'b0;
    div_dvd   = TPS;
    div_dsr   = CNT_W'(1) << wl;
    if (((st_q == ST_IDLE) && arm_pend_q) || ((st_q == ST_RUN) && need_calc)) begin
      div_start = 1'b1;
    end else if (ev_go_late) begin
      div_start = 1'b1;
      div_dvd   = late_d;
      div_dsr   = ticks_o;
    end
  end

  logic             upd_hit, alm_hit, per_hit, any_hit;
  logic [CNT_W-1:0] sub_next;
  logic [15:0]      status_next;

  rtc_flag_eval #(.SUB_W(CNT_W)) u_eval (
    .en_i         (en),
    .sec_i        (time_sec_i),
    .min_i        (time_min_i),
    .hr_i         (time_hr_i),
    .al_sec_i     (al_sec),
    .al_min_i     (al_min),
    .al_hr_i      (al_hr),
    .last_sec_i   (last_sec_q),
    .sub_i        (sub_q),
    .thr_i        (thr),
    .upd_hit_o    (upd_hit),
    .alm_hit_o    (alm_hit),
    .per_hit_o    (per_hit),
    .sub_next_o   (sub_next),
    .status_next_o(status_next),
    .any_o        (any_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      arm_pend_q   <= 1'b0;
      ticks_log_q  <= '0;
      ticks_o      <= '0;
      cmp_value_o  <= '0;
      cmp_active_o <= 1'b0;
      skip_base    <= '0;
      sub_q        <= '0;
      last_sec_q   <= '0;
      irq_q        <= 1'b0;
      status_q     <= '0;
    end else begin
      irq_q      <= 1'b0;
      arm_pend_q <= (ev_calc_done ? 1'b0 : arm_pend_q) | arm_evt;

      if (sub_clr)                         sub_q <= '0;
      else if (ev_skip_done && en[SRC_PER]) sub_q <= CNT_W'(sat_add(64'(sub_q), 64'(missed), CNT_W));
      else if (st_q == ST_EVAL)            sub_q <= sub_next;

      unique case (st_q)
        ST_IDLE: if (arm_pend_q) begin
          ticks_log_q <= wl;
          st_q        <= ST_CALC;
        end
        ST_CALC: if (div_done) begin
          ticks_o <= calc_ticks;
          if (arm_pend_q) begin
            cmp_value_o  <= count_i + calc_ticks;
            cmp_active_o <= 1'b1;
          end
          st_q <= (arm_pend_q || cmp_active_o) ? ST_RUN : ST_IDLE;
        end
        ST_RUN: begin
          if (need_calc) begin
            ticks_log_q <= wl;
            st_q        <= ST_CALC;
          end else if (ev_retire) begin
            cmp_active_o <= 1'b0;
            st_q         <= ST_IDLE;
          end else if (ev_go_late) begin
            skip_base <= count_i;
            st_q      <= ST_LATE;
          end else if (ev_ontime) begin
            cmp_value_o <= next_cmp;
            st_q        <= ST_EVAL;
          end
        end
        ST_LATE: if (div_done) begin
          cmp_value_o <= skip_cmp;
          st_q        <= ST_EVAL;
        end
        ST_EVAL: begin
          if (upd_hit) last_sec_q <= time_sec_i;
          if (any_hit) begin
            irq_q    <= 1'b1;
            status_q <= status_next;
          end
          st_q <= ST_RUN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign irq_o    = irq_q;
  assign status_o = status_q;

endmodule

// File: rtl/rtc_wake_sched_chk.sv
module rtc_wake_sched_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic [15:0]      status_o,
  input logic             cmp_active_o,
  input logic [CNT_W-1:0] cmp_value_o,
  input logic [CNT_W-1:0] ticks_o,
  input logic [CNT_W-1:0] skip_base,
  input logic             ev_ontime,
  input logic             ev_calc_done,
  input logic             ev_skip_done
);
  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_status_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o[15:8] == 8'd1) && status_o[7] &&
              (status_o[6:4] != 3'b000) && (status_o[3:0] == 4'h0));

  assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> $stable(status_o));

  assert_irq_needs_channel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cmp_active_o);

  assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ontime |=> cmp_value_o == $past(cmp_value_o) + $past(ticks_o));

  assert_skip_ahead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip_done |=> $signed(cmp_value_o - $past(skip_base)) > 0);

  assert_arm_after_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_active_o) |-> $past(ev_calc_done));

  assert_ticks_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_active_o |-> (ticks_o != '0));
endmodule

bind rtc_wake_sched rtc_wake_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_o       (irq_o),
  .status_o    (status_o),
  .cmp_active_o(cmp_active_o),
  .cmp_value_o (cmp_value_o),
  .ticks_o     (ticks_o),
  .skip_base   (skip_base),
  .ev_ontime   (ev_ontime),
  .ev_calc_done(ev_calc_done),
  .ev_skip_done(ev_skip_done)
);

// File: tb/rtc_wake_sched_test.sv
module rtc_wake_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] counter = '0;
  logic [5:0]  t_sec = '0, t_min = '0;
  logic [4:0]  t_hr = '0;
  logic [2:0]  s_set = '0, s_clr = '0;
  logic        a_wr = 1'b0;
  logic [5:0]  a_sec = '0, a_min = '0;
  logic [4:0]  a_hr = '0;
  logic        r_wr = 1'b0;
  logic [3:0]  r_log = '0;
  logic        irq_o, cmp_active_o;
  logic [15:0] status_o;
  logic [31:0] cmp_value_o, ticks_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  rtc_wake_sched uut (
    .clk(clk), .rst_n(rst_n), .count_i(counter),
    .time_sec_i(t_sec), .time_min_i(t_min), .time_hr_i(t_hr),
    .src_set_i(s_set), .src_clr_i(s_clr),
    .alarm_wr_i(a_wr), .alarm_sec_i(a_sec), .alarm_min_i(a_min), .alarm_hr_i(a_hr),
    .rate_wr_i(r_wr), .rate_log_i(r_log),
    .irq_o(irq_o), .status_o(status_o), .cmp_active_o(cmp_active_o),
    .cmp_value_o(cmp_value_o), .ticks_o(ticks_o)
  );

  typedef struct packed {
    logic [3:0]  rate;
    logic [15:0] ticks;
    logic [7:0]  thr;
  } vec_t;

  // rate code, expected ticks (16384 per second), wake-ups per periodic flag
  localparam vec_t VECS [8] = '{
    '{4'd1,  16'd256, 8'd32},
    '{4'd3,  16'd256, 8'd8},
    '{4'd6,  16'd256, 8'd1},
    '{4'd7,  16'd128, 8'd1},
    '{4'd10, 16'd16,  8'd1},
    '{4'd13, 16'd2,   8'd1},
    '{4'd0,  16'd256, 8'd32},
    '{4'd15, 16'd2,   8'd1}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s_set = '0; s_clr = '0; a_wr = 1'b0; r_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic en_set(input logic [2:0] m);
    @(negedge clk); s_set = m;
    @(negedge clk); s_set = '0;
  endtask

  task automatic en_clr(input logic [2:0] m);
    @(negedge clk); s_clr = m;
    @(negedge clk); s_clr = '0;
  endtask

  task automatic rate_write(input logic [3:0] v);
    @(negedge clk); r_wr = 1'b1; r_log = v;
    @(negedge clk); r_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic wake(output bit got, output logic [15:0] st);
    got = 1'b0; st = '0;
    @(negedge clk); counter = cmp_value_o;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (irq_o) begin got = 1'b1; st = status_o; end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bit          got;
    logic [15:0] st;
    logic [31:0] base, prev;

    // R1 reset state
    do_reset();
    chk(!irq_o && status_o == 16'h0 && !cmp_active_o, "R1 reset outputs",
        {irq_o, cmp_active_o, status_o}, 64'h0);

    // R2 R3 R4 R5 R8 R11: table of rate codes
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      bit   adv_ok;
      bit   pre_ok;
      v = VECS[i];
      adv_ok = 1'b1;
      pre_ok = 1'b1;
      do_reset();
      base = 32'(1000 + i * 100000);
      counter = base;
      rate_write(v.rate);
      en_set(3'b100);
      settle();
      chk(ticks_o == 32'(v.ticks), "R3 R4 ticks per wake-up", ticks_o, v.ticks);
      chk(cmp_active_o && cmp_value_o == base + 32'(v.ticks), "R2 arm value",
          cmp_value_o, base + 32'(v.ticks));
      for (int k = 1; k <= int'(v.thr); k++) begin
        prev = cmp_value_o;
        wake(got, st);
        if (cmp_value_o != prev + 32'(v.ticks)) adv_ok = 1'b0;
        if (k < int'(v.thr) && got) pre_ok = 1'b0;
        if (k == int'(v.thr))
          chk(got && st == 16'h01C0, "R8 R11 periodic flag status", {got, st}, 17'h101C0);
      end
      chk(adv_ok, "R5 comparator advance", adv_ok, 1);
      chk(pre_ok, "R8 no early periodic flag", pre_ok, 1);
    end

    // R7 update flag, R11 status hold
    do_reset();
    counter = 32'd5000; t_sec = 6'd5;
    en_set(3'b001);
    settle();
    wake(got, st);
    chk(got && st == 16'h0190, "R7 update on new second", {got, st}, 17'h10190);
    wake(got, st);
    chk(!got, "R7 no update on same second", got, 0);
    chk(status_o == 16'h0190, "R11 status held", status_o, 16'h0190);
    t_sec = 6'd6;
    wake(got, st);
    chk(got && st == 16'h0190, "R7 update on next second", {got, st}, 17'h10190);

    // R1 all sources off retires the channel at next wake-up
    en_clr(3'b111);
    t_sec = 6'd7;
    wake(got, st);
    chk(!got && !cmp_active_o, "R1 channel off, no irq", {got, cmp_active_o}, 0);

    // R9 alarm
    do_reset();
    counter = 32'd9000;
    @(negedge clk); a_wr = 1'b1; a_hr = 5'd1; a_min = 6'd2; a_sec = 6'd3;
    @(negedge clk); a_wr = 1'b0;
    t_hr = 5'd1; t_min = 6'd2; t_sec = 6'd3;
    en_set(3'b010);
    settle();
    wake(got, st);
    chk(got && st == 16'h01A0, "R9 alarm match", {got, st}, 17'h101A0);
    t_min = 6'd4;
    wake(got, st);
    chk(!got, "R9 no alarm on minute mismatch", got, 0);

    // R6 late wake-up skip, sub-count credited
    do_reset();
    counter = 32'd20000;
    rate_write(4'd3);
    en_set(3'b100);
    settle();
    base = cmp_value_o;
    @(negedge clk); counter = base + 32'd778;
    repeat (60) @(negedge clk);
    chk(cmp_value_o == base + 32'd1280, "R6 skip target", cmp_value_o, base + 32'd1280);
    wake(got, st);
    chk(!got, "R6 first wake after skip quiet", got, 0);
    wake(got, st);
    chk(!got, "R6 second wake after skip quiet", got, 0);
    wake(got, st);
    chk(got && st == 16'h01C0, "R6 credited count flags early", {got, st}, 17'h101C0);

    // R10 rate write clears sub-count
    do_reset();
    counter = 32'd40000;
    rate_write(4'd3);
    en_set(3'b100);
    settle();
    for (int k = 0; k < 5; k++) wake(got, st);
    rate_write(4'd3);
    begin
      bit quiet;
      quiet = 1'b1;
      for (int k = 0; k < 7; k++) begin
        wake(got, st);
        if (got) quiet = 1'b0;
      end
      chk(quiet, "R10 no flag before full count", quiet, 1);
    end
    wake(got, st);
    chk(got && st == 16'h01C0, "R10 flag after restarted count", {got, st}, 17'h101C0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule